// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the hardwired control unit of a small single-bus processor. A step counter is decoded into one-hot time-step lines T1..Tn. The opcode held in the instruction register is decoded into one line per instruction. Fixed sum-of-products equations combine the time steps, the instruction lines and the negative flag to produce the datapath strobe `zin_o`, which loads the ALU result latch, and the sequence terminator `end_o`.

When `end_o` is high and the unit is allowed to run, the counter restarts at T1, which is the instruction fetch step. While `run_i` is low, for example while memory has not yet completed an access, the counter holds its step. `run_i` works as a synchronous count enable, so the clock is never gated. The unit supports three instructions: an add with a memory operand (seven steps), an unconditional jump (six steps), and a jump taken on a negative result (four steps when not taken, six when taken). An undefined opcode is retired at a fixed step, so the unit always returns to fetch.

Top module: `hw_step_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `step_o` equals 1, meaning T1 is active (bit k-1 of `step_o` is step Tk).
- R2: `step_o` has exactly one bit set in every cycle.
- R3: With `run_i`=1 and `end_o`=0, and the current step not the last one, the active step moves from Tk to Tk+1 at the next rising edge.
- R4: With `run_i`=0, `step_o` keeps its value at the next rising edge, even when `end_o` is high.
- R5: With `run_i`=1 and `end_o`=1, T1 is active after the next rising edge.
- R6: `zin_o` is high in T1 for every opcode, in T6 for the add, and in T5 for either jump. It is low in every other case.
- R7: Opcode encoding: 2'b00 is the add and 2'b01 is the unconditional jump. `end_o` is high in T7 for the add and in T6 for the jump, and low in every other step.
- R8: Opcode 2'b10 is the jump on negative. `end_o` is high in T4 when `neg_i`=0, and in T6 whatever the value of `neg_i`.
- R9: Opcode 2'b11 is undefined. Its `end_o` is high only in T4 (the fixed retire step), and its `zin_o` is high only in T1.
- R10: With `run_i`=1 and `end_o`=0 in the last step (T8 by default), T1 is active after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset, which forces T1 |
| run_i | input | 1 | Count enable. Low holds the current step |
| opcode_i | input | 2 | Opcode field of the instruction register |
| neg_i | input | 1 | Negative flag from the datapath |
| step_o | output | NUM_STEPS (8) | One-hot time steps, with bit k-1 being Tk |
| zin_o | output | 1 | Load strobe for the ALU result latch |
| end_o | output | 1 | End of the control sequence, which restarts fetch |

## Verification
The bench stalls the unit in the same step as a pending `end_o`. A design that let the restart override the stall would jump back to fetch and lose the memory wait. The jump on negative is run with the flag both clear and set, and with the flag changing between T4 and T6. A design that mixed up the two end points would either retire a taken branch early or run a not-taken one too long. The undefined opcode must retire at T4; otherwise the sequencer would run off into unused steps. An opcode changed in the middle of a sequence drives the counter into T8, and the bench checks that it then wraps to T1 rather than into a value outside the one-hot range.

// File: rtl/hw_seq_pkg.sv
package hw_seq_pkg;

  localparam int OPC_W   = 2;
  localparam int NUM_INS = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADDM = 2'b00,
    OPC_JMP  = 2'b01,
    OPC_JNEG = 2'b10,
    OPC_RSVD = 2'b11
  } opcode_e;

  // Index of each decoded instruction line
  localparam int INS_ADDM = 0;
  localparam int INS_JMP  = 1;
  localparam int INS_JNEG = 2;
  localparam int INS_NONE = 3;

  // Load strobe for the ALU result latch
  function automatic logic zin_eq(input logic t1, input logic t5, input logic t6,
                                  input logic addm, input logic jmp, input logic jneg);
    return t1 | (t6 & addm) | (t5 & jmp) | (t5 & jneg);
  endfunction

  // Sequence terminator; t_fb is the fixed retire step for undefined opcodes
  function automatic logic end_eq(input logic t4, input logic t6, input logic t7,
                                  input logic t_fb, input logic neg,
                                  input logic addm, input logic jmp,
                                  input logic jneg, input logic none);
    return (t7 & addm) | (t6 & jmp) | (t4 & ~neg & jneg) | (t6 & jneg) |
           (t_fb & none);
  endfunction

endpackage

// File: rtl/hw_step_counter.sv
module hw_step_counter #(
  parameter int NUM_STEPS = 8,
  localparam int STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              restart_i,
  output logic [STEP_W-1:0] count_o
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] count_q;
  logic [STEP_W-1:0] count_nx;

  always_comb begin
    if (restart_i || count_q == LAST) count_nx = '0;
    else                              count_nx = count_q + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        count_q <= '0;
    else if (run_i) count_q <= count_nx;
  end

  assign count_o = count_q;

endmodule

// File: rtl/hw_step_decoder.sv
module hw_step_decoder #(
  parameter int NUM_STEPS = 8,
  localparam int STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic [STEP_W-1:0]    count_i,
  output logic [NUM_STEPS-1:0] step_o
);

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    assign step_o[g] = (count_i == STEP_W'(g));
  end

endmodule

// File: rtl/hw_instr_decoder.sv
module hw_instr_decoder
  import hw_seq_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode_i,
  output logic [NUM_INS-1:0] instr_o
);

  always_comb begin
    instr_o = '0;
    case (opcode_e'(opcode_i))
      OPC_ADDM: instr_o[INS_ADDM] = 1'b1;
      OPC_JMP:  instr_o[INS_JMP]  = 1'b1;
      OPC_JNEG: instr_o[INS_JNEG] = 1'b1;
      default:  instr_o[INS_NONE] = 1'b1;
    endcase
  end

endmodule

// File: rtl/hw_step_sequencer.sv
module hw_step_sequencer
  import hw_seq_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int RETIRE_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic [1:0]           opcode_i,
  input  logic                 neg_i,
  output logic [NUM_STEPS-1:0] step_o,
  output logic                 zin_o,
  output logic                 end_o
);

  localparam int STEP_W = $clog2(NUM_STEPS);

  logic [STEP_W-1:0]    count_w;
  logic [NUM_INS-1:0]   instr_w;
  logic [NUM_STEPS-1:0] step_w;
  logic                 restart_w;

  hw_step_counter #(.NUM_STEPS(NUM_STEPS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_i),
    .restart_i (restart_w),
    .count_o   (count_w)
  );

  hw_step_decoder #(.NUM_STEPS(NUM_STEPS)) u_sdec (
    .count_i (count_w),
    .step_o  (step_w)
  );

  hw_instr_decoder u_idec (
    .opcode_i (opcode_i),
    .instr_o  (instr_w)
  );

  // Steps are 1-based in the equations: Tk is step_w[k-1]
  assign zin_o = zin_eq(step_w[0], step_w[4], step_w[5],
                        instr_w[INS_ADDM], instr_w[INS_JMP], instr_w[INS_JNEG]);

  assign restart_w = end_eq(step_w[3], step_w[5], step_w[6], step_w[RETIRE_STEP-1],
                            neg_i, instr_w[INS_ADDM], instr_w[INS_JMP],
                            instr_w[INS_JNEG], instr_w[INS_NONE]);

  assign end_o  = restart_w;
  assign step_o = step_w;

endmodule

// File: rtl/hw_step_sequencer_chk.sv
module hw_step_sequencer_chk #(
  parameter int NUM_STEPS = 8,
  parameter int NUM_INS   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run_i,
  input logic [1:0]           opcode_i,
  input logic                 neg_i,
  input logic [NUM_STEPS-1:0] step_o,
  input logic                 zin_o,
  input logic                 end_o,
  input logic [NUM_INS-1:0]   instr_w
);

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(step_o)); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    run_i && !end_o && !step_o[NUM_STEPS-1] |=> step_o == ($past(step_o) << 1)); // R3

  AST_STEP_STALL: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(step_o)); // R4

  AST_END_RESTART: assert property (@(posedge clk) disable iff (rst)
    run_i && end_o |=> step_o[0]); // R5

  AST_FETCH_ZIN: assert property (@(posedge clk) disable iff (rst)
    step_o[0] |-> zin_o); // R6

  AST_JNEG_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    opcode_i == 2'b10 && step_o[3] && !neg_i |-> end_o); // R8

  AST_INSTR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(instr_w)); // R9

  AST_LAST_WRAP: assert property (@(posedge clk) disable iff (rst)
    run_i && !end_o && step_o[NUM_STEPS-1] |=> step_o[0]); // R10

endmodule

bind hw_step_sequencer hw_step_sequencer_chk #(
  .NUM_STEPS (NUM_STEPS),
  .NUM_INS   (hw_seq_pkg::NUM_INS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .run_i    (run_i),
  .opcode_i (opcode_i),
  .neg_i    (neg_i),
  .step_o   (step_o),
  .zin_o    (zin_o),
  .end_o    (end_o),
  .instr_w  (instr_w)
);

// File: tb/hw_step_sequencer_tb_top.sv
`timescale 1ns/1ps
module hw_step_sequencer_tb_top;

  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_i = 1'b0;
  logic [1:0]    opcode_i = 2'b00;
  logic          neg_i = 1'b0;
  logic [NS-1:0] step_o;
  logic          zin_o;
  logic          end_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_step = 1;        // 1-based expected step
  string why = "R1";       // requirement behind the latest step transition

  always #2 clk = ~clk;    // 250 MHz

  hw_step_sequencer dut_i (
    .clk(clk), .rst(rst), .run_i(run_i), .opcode_i(opcode_i), .neg_i(neg_i),
    .step_o(step_o), .zin_o(zin_o), .end_o(end_o)
  );

  function automatic bit ref_zin(int s, logic [1:0] op);
    if (s == 1) return 1'b1;
    case (op)
      2'b00:   return s == 6;
      2'b01,
      2'b10:   return s == 5;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_end(int s, logic [1:0] op, bit n);
    case (op)
      2'b00:   return s == 7;
      2'b01:   return s == 6;
      2'b10:   return (s == 6) || (s == 4 && !n);
      default: return s == 4;
    endcase
  endfunction

  function automatic string end_req(logic [1:0] op);
    case (op)
      2'b10:   return "R8";
      2'b11:   return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check before rising edge, advance model
  task automatic cyc(bit run, logic [1:0] op, bit n);
    bit e;
    @(negedge clk);
    run_i = run; opcode_i = op; neg_i = n;
    #1;
    check(step_o == NS'(1) << (exp_step - 1), why, "step", step_o,
          int'(NS'(1) << (exp_step - 1)));
    check($onehot(step_o), "R2", "onehot", step_o, 1);
    check(zin_o == ref_zin(exp_step, op), (op == 2'b11) ? "R9" : "R6", "zin",
          zin_o, ref_zin(exp_step, op));
    e = ref_end(exp_step, op, n);
    check(end_o == e, end_req(op), "end", end_o, e);
    @(posedge clk);
    if (!run)                 why = "R4";
    else if (e)               begin why = "R5";  exp_step = 1; end
    else if (exp_step == NS)  begin why = "R10"; exp_step = 1; end
    else                      begin why = "R3";  exp_step++; end
  endtask

  // Run one instruction to completion with run held high
  task automatic run_instr(logic [1:0] op, bit n);
    int guard = 0;
    do begin
      cyc(1'b1, op, n);
      guard++;
    end while (exp_step != 1 && guard < 20);
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    #1;
    check(step_o == NS'(1), "R1", "reset step", step_o, 1);
    @(negedge clk);
    rst = 1'b0;
    exp_step = 1; why = "R1";

    run_instr(2'b00, 1'b0);               // R7 add: ends at T7
    run_instr(2'b01, 1'b0);               // R7 jump: ends at T6
    run_instr(2'b10, 1'b0);               // R8 not taken: T4
    run_instr(2'b10, 1'b1);               // R8 taken: T6
    run_instr(2'b11, 1'b0);               // R9 undefined: T4

    // R8: flag set at T4, clear afterwards -> still ends at T6
    for (int i = 0; i < 4; i++) cyc(1'b1, 2'b10, 1'b1);
    cyc(1'b1, 2'b10, 1'b0);
    cyc(1'b1, 2'b10, 1'b0);

    // R4: stall mid-sequence and on an END step
    for (int i = 0; i < 3; i++) cyc(1'b1, 2'b01, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 2'b01, 1'b0);
    for (int i = 0; i < 2; i++) cyc(1'b1, 2'b01, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 2'b01, 1'b0); // at T6, end high
    cyc(1'b1, 2'b01, 1'b0);

    // R10: add up to T7, then switch to jump so T8 is reached and wraps
    for (int i = 0; i < 6; i++) cyc(1'b1, 2'b00, 1'b0);
    cyc(1'b1, 2'b01, 1'b0);
    cyc(1'b1, 2'b01, 1'b0);
    cyc(1'b1, 2'b01, 1'b0);

    // Random instructions with random stalls and flag
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      do begin
        cyc(($urandom_range(0, 3) != 0), op, 1'($urandom_range(0, 1)));
      end while (exp_step != 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule